// File: doc/BRIEF.md
# Multi-CPU device interrupt controller

The block gathers up to 64 level-sensitive device interrupt lines into a raw pending register and gives each of four CPUs a private 64-bit enable mask. A CPU's hard-interrupt output is raised whenever its mask, ANDed with the raw pending bits, is non-zero. A separate legacy-controller input is folded into raw bit 55.

A control/status word on the same register bus carries two groups of per-CPU status bits. The interprocessor-interrupt (IPI) bits drive the IPI outputs. The interval-timer bits drive the timer outputs. The word's fields behave differently from one another: some are write-one-to-clear, some write-one-to-set, one is set only when it is empty, some are set through a shifted request field, and some are plain read/write. Timer status bits are set by per-CPU tick inputs. Software can only clear them.

Software reaches the block through a 64-bit register bus with combinational read data. Each access carries a read strobe, a write strobe, a 12-bit byte offset, a full-width qualifier and the index of the CPU making the access. Offsets that are reserved but defined read as zero and ignore writes. Offsets that are not defined, and accesses narrower than 64 bits, raise an access error.

Top module: `dev_irq_hub`

## Requirements
- R1: The raw register (offset 0x300) holds, one clock after sampling, bit k = dev_irq_i[k]. Bit 55 is also set while legacy_irq_i is high.
- R2: Full writes to offsets 0x200, 0x240, 0x600 and 0x640 store all 64 bits as the mask of CPU 0, 1, 2 and 3 respectively. The write touches only that CPU's mask, and the value reads back at the same offset.
- R3: Offsets 0x280, 0x2C0, 0x680 and 0x6C0 read CPU 0..3's mask AND the raw register.
- R4: Writes to the request offsets and to the raw offset change nothing.
- R5: hard_irq_o[i] is high exactly when CPU i's mask AND the raw register is non-zero, following register state with no added delay.
- R6: The control word sits at offset 0x080 and resets to 0x0000_0008_0000_0000. A read returns bus_cpu_i in bits [1:0].
- R7: Ones written to control bits [11:4] or bit 28 clear those bits.
- R8: A control write with bit 20 set clears bits [23:16]. Without bit 20, ones in [23:20] are set, and ones in [19:16] are set only if [19:16] is currently all zero.
- R9: Ones written to control bits [15:12] set bits [11:8], and this set wins over a clear in the same write. ipi_o[i] equals bit 8+i.
- R10: timer_irq_o[i] equals control bit 4+i. timer_set_i[i] sets the bit, and wins over a same-cycle clear. A write can never set it.
- R11: Control bits [43:40] are plain read/write. Other unlisted bits ignore writes.
- R12: bus_err_o is high during a strobe when bus_full_i is low or the offset is undefined. An erroring access reads zero and writes nothing.
- R13: The defined reserved offsets (0x000, 0x040, 0x0C0, 0x100-0x1C0, 0x340-0x4C0, 0x580, 0x5C0, 0x700-0x780, 0xC00-0xCC0 on 0x40 steps) read zero without error and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dev_irq_i | input | 64 | Level-sensitive device interrupt lines |
| legacy_irq_i | input | 1 | Legacy cascaded controller request, folded into bit 55 |
| timer_set_i | input | 4 | Per-CPU interval timer tick, sets timer status |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_full_i | input | 1 | Access is full 64-bit width |
| bus_cpu_i | input | 2 | Index of the accessing CPU |
| bus_addr_i | input | 12 | Byte offset |
| bus_wdata_i | input | 64 | Write data |
| bus_rdata_o | output | 64 | Read data, valid while bus_rd_i is high |
| bus_err_o | output | 1 | Access error |
| hard_irq_o | output | 4 | Per-CPU device interrupt |
| ipi_o | output | 4 | Per-CPU interprocessor interrupt |
| timer_irq_o | output | 4 | Per-CPU interval timer interrupt |

## Verification
Two collisions are provoked on purpose. A timer tick and a control write that clears the same timer bit fall in one cycle, and the bit must stay set. A single control write both clears and requests IPI bits, and the request must win. The bench also changes device lines in the same cycle as a mask write, so the hard-interrupt output must reflect both new values at the following edge. Its cycle model predicts every output on every clock.

// File: rtl/dih_pkg.sv
package dih_pkg;
  localparam int NCPU   = 4;
  localparam int IDX_W  = 2;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 64;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 12'h080;
  localparam logic [ADDR_W-1:0] OFF_RAW  = 12'h300;

  localparam logic [DATA_W-1:0] CTRL_RST  = 64'h0000_0008_0000_0000;
  localparam logic [DATA_W-1:0] CTRL_W1C  = 64'h0000_0000_1000_0ff0;
  localparam logic [DATA_W-1:0] CTRL_RW   = 64'h0000_0f00_0000_0000;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_ZERO, SEL_CTRL, SEL_MASK, SEL_REQ, SEL_RAW
  } sel_e;

  typedef struct packed {
    sel_e             sel;
    logic [IDX_W-1:0] idx;
    logic             err;
  } dec_t;
endpackage

// File: rtl/dih_addr_dec.sv
module dih_addr_dec
  import dih_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              full_i,
  output dec_t              dec_o
);
  dec_t d;

  always_comb begin
    d = '{sel: SEL_NONE, idx: '0, err: 1'b0};
    case (addr_i)
      12'h080: d.sel = SEL_CTRL;
      12'h300: d.sel = SEL_RAW;
      12'h200: begin d.sel = SEL_MASK; d.idx = 2'd0; end
      12'h240: begin d.sel = SEL_MASK; d.idx = 2'd1; end
      12'h600: begin d.sel = SEL_MASK; d.idx = 2'd2; end
      12'h640: begin d.sel = SEL_MASK; d.idx = 2'd3; end
      12'h280: begin d.sel = SEL_REQ;  d.idx = 2'd0; end
      12'h2c0: begin d.sel = SEL_REQ;  d.idx = 2'd1; end
      12'h680: begin d.sel = SEL_REQ;  d.idx = 2'd2; end
      12'h6c0: begin d.sel = SEL_REQ;  d.idx = 2'd3; end
      12'h000, 12'h040, 12'h0c0,
      12'h100, 12'h140, 12'h180, 12'h1c0,
      12'h340, 12'h380, 12'h3c0,
      12'h400, 12'h440, 12'h480, 12'h4c0,
      12'h580, 12'h5c0,
      12'h700, 12'h740, 12'h780,
      12'hc00, 12'hc40, 12'hc80, 12'hcc0: d.sel = SEL_ZERO;
      default: d.sel = SEL_NONE;
    endcase
    d.err = (d.sel == SEL_NONE) || !full_i;
  end

  assign dec_o = d;
endmodule

// File: rtl/dih_mask_bank.sv
module dih_mask_bank #(
  parameter int NCPU  = 4,
  parameter int W     = 64,
  localparam int IDX_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [IDX_W-1:0]         wr_idx_i,
  input  logic [W-1:0]             wdata_i,
  input  logic [W-1:0]             raw_i,
  output logic [NCPU-1:0][W-1:0]   mask_o,
  output logic [NCPU-1:0]          hard_o
);
  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [W-1:0] mask_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mask_q <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(c))     mask_q <= wdata_i;
    end
    assign mask_o[c] = mask_q;
    assign hard_o[c] = |(mask_q & raw_i);
  end
endmodule

// File: rtl/dih_ctrl_reg.sv
module dih_ctrl_reg
  import dih_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NCPU-1:0]   timer_set_i,
  output logic [DATA_W-1:0] ctrl_o
);
  logic [DATA_W-1:0] q, d;

  always_comb begin
    d = q;
    if (wr_en_i) begin
      d = d & ~(wdata_i & CTRL_W1C);
      if (wdata_i[20]) begin
        d[23:16] = '0;
      end else begin
        d[23:20] = d[23:20] | wdata_i[23:20];
        // lower nibble only latches into an empty field
        if (q[19:16] == '0) d[19:16] = wdata_i[19:16];
      end
      d[11:8] = d[11:8] | wdata_i[15:12];
      d = (d & ~CTRL_RW) | (wdata_i & CTRL_RW);
    end
    // tick beats a same-cycle software clear
    d[7:4] = d[7:4] | timer_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= CTRL_RST;
    else         q <= d;
  end

  assign ctrl_o = q;
endmodule

// File: rtl/dev_irq_hub.sv
module dev_irq_hub
  import dih_pkg::*;
#(
  parameter int LEGACY_BIT = 55
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] dev_irq_i,
  input  logic              legacy_irq_i,
  input  logic [NCPU-1:0]   timer_set_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic              bus_full_i,
  input  logic [IDX_W-1:0]  bus_cpu_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_err_o,
  output logic [NCPU-1:0]   hard_irq_o,
  output logic [NCPU-1:0]   ipi_o,
  output logic [NCPU-1:0]   timer_irq_o
);
  dec_t                          dec;
  logic [DATA_W-1:0]             raw_q, ctrl;
  logic [NCPU-1:0][DATA_W-1:0]   mask;
  logic                          wr_ok;

  dih_addr_dec u_dec (
    .addr_i (bus_addr_i),
    .full_i (bus_full_i),
    .dec_o  (dec)
  );

  assign wr_ok = bus_wr_i && !dec.err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= '0;
    else         raw_q <= dev_irq_i | (DATA_W'(legacy_irq_i) << LEGACY_BIT);
  end

  dih_mask_bank #(.NCPU(NCPU), .W(DATA_W)) u_masks (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_ok && dec.sel == SEL_MASK),
    .wr_idx_i (dec.idx),
    .wdata_i  (bus_wdata_i),
    .raw_i    (raw_q),
    .mask_o   (mask),
    .hard_o   (hard_irq_o)
  );

  dih_ctrl_reg u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_ok && dec.sel == SEL_CTRL),
    .wdata_i     (bus_wdata_i),
    .timer_set_i (timer_set_i),
    .ctrl_o      (ctrl)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_rd_i && !dec.err) begin
      case (dec.sel)
        SEL_CTRL: bus_rdata_o = ctrl | DATA_W'(bus_cpu_i);
        SEL_MASK: bus_rdata_o = mask[dec.idx];
        SEL_REQ:  bus_rdata_o = mask[dec.idx] & raw_q;
        SEL_RAW:  bus_rdata_o = raw_q;
        default:  bus_rdata_o = '0;
      endcase
    end
  end

  assign bus_err_o   = (bus_rd_i || bus_wr_i) && dec.err;
  assign ipi_o       = ctrl[11:8];
  assign timer_irq_o = ctrl[7:4];
endmodule

// File: rtl/dih_checker.sv
module dih_checker
  import dih_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] dev_irq_i,
  input logic              legacy_irq_i,
  input logic [NCPU-1:0]   timer_set_i,
  input logic              bus_rd_i,
  input logic              bus_wr_i,
  input logic              bus_full_i,
  input logic [IDX_W-1:0]  bus_cpu_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              bus_err_o,
  input logic [NCPU-1:0]   hard_irq_o,
  input logic [NCPU-1:0]   ipi_o,
  input logic [NCPU-1:0]   timer_irq_o
);
  assert_quiet_lines_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_irq_i == '0 && !legacy_irq_i) |=> hard_irq_o == '0);

  assert_cpu_index_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_full_i && bus_addr_i == OFF_CTRL) |-> bus_rdata_o[1:0] == bus_cpu_i);

  assert_ipi_request_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_full_i && bus_addr_i == OFF_CTRL && bus_wdata_i[15:12] != '0)
    |=> (ipi_o & $past(bus_wdata_i[15:12])) == $past(bus_wdata_i[15:12]));

  assert_timer_no_sw_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timer_set_i == '0) |=> (timer_irq_o & ~$past(timer_irq_o)) == '0);

  assert_narrow_access_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((bus_rd_i || bus_wr_i) && !bus_full_i) |-> bus_err_o);

  assert_err_reads_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_err_o) |-> bus_rdata_o == '0);
endmodule

bind dev_irq_hub dih_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dev_irq_i    (dev_irq_i),
  .legacy_irq_i (legacy_irq_i),
  .timer_set_i  (timer_set_i),
  .bus_rd_i     (bus_rd_i),
  .bus_wr_i     (bus_wr_i),
  .bus_full_i   (bus_full_i),
  .bus_cpu_i    (bus_cpu_i),
  .bus_addr_i   (bus_addr_i),
  .bus_wdata_i  (bus_wdata_i),
  .bus_rdata_o  (bus_rdata_o),
  .bus_err_o    (bus_err_o),
  .hard_irq_o   (hard_irq_o),
  .ipi_o        (ipi_o),
  .timer_irq_o  (timer_irq_o)
);

// File: tb/dev_irq_hub_tb_top.sv
module dev_irq_hub_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] dev_irq_i = '0;
  logic        legacy_irq_i = 1'b0;
  logic [3:0]  timer_set_i = '0;
  logic        bus_rd_i = 1'b0, bus_wr_i = 1'b0, bus_full_i = 1'b1;
  logic [1:0]  bus_cpu_i = '0;
  logic [11:0] bus_addr_i = '0;
  logic [63:0] bus_wdata_i = '0;
  logic [63:0] bus_rdata_o;
  logic        bus_err_o;
  logic [3:0]  hard_irq_o, ipi_o, timer_irq_o;

  int total = 0, bad = 0;
  bit finished = 0;
  string rd_tag = "R1";

  // reference state
  logic [63:0] m_raw = '0;
  logic [63:0] m_ctrl = 64'h0000_0008_0000_0000;
  logic [63:0] m_mask [4] = '{default: '0};

  always #5 clk_i = ~clk_i;

  dev_irq_hub dut_i (.*);

  function automatic int mask_slot(input logic [11:0] a);
    case (a)
      12'h200: return 0; 12'h240: return 1; 12'h600: return 2; 12'h640: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic int req_slot(input logic [11:0] a);
    case (a)
      12'h280: return 0; 12'h2c0: return 1; 12'h680: return 2; 12'h6c0: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic bit is_reserved(input logic [11:0] a);
    if (a[5:0] != 0) return 0;
    if (a == 12'h000 || a == 12'h040 || a == 12'h0c0) return 1;
    if (a >= 12'h100 && a <= 12'h1c0) return 1;
    if (a >= 12'h340 && a <= 12'h4c0) return 1;
    if (a == 12'h580 || a == 12'h5c0) return 1;
    if (a >= 12'h700 && a <= 12'h780) return 1;
    if (a >= 12'hc00 && a <= 12'hcc0) return 1;
    return 0;
  endfunction

  function automatic bit is_known(input logic [11:0] a);
    return a == 12'h080 || a == 12'h300 || mask_slot(a) >= 0 ||
           req_slot(a) >= 0 || is_reserved(a);
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit e;
    logic [63:0] rexp;
    for (int i = 0; i < 4; i++)
      check(64'(hard_irq_o[i]), 64'(|(m_mask[i] & m_raw)), "R5 hard_irq");
    check(64'(ipi_o), 64'(m_ctrl[11:8]), "R9 ipi");
    check(64'(timer_irq_o), 64'(m_ctrl[7:4]), "R10 timer");
    e = (bus_rd_i || bus_wr_i) && (!bus_full_i || !is_known(bus_addr_i));
    check(64'(bus_err_o), 64'(e), "R12 err");
    if (bus_rd_i) begin
      rexp = '0;
      if (!e) begin
        if (bus_addr_i == 12'h080)          rexp = m_ctrl | 64'(bus_cpu_i);
        else if (bus_addr_i == 12'h300)     rexp = m_raw;
        else if (mask_slot(bus_addr_i) >= 0) rexp = m_mask[mask_slot(bus_addr_i)];
        else if (req_slot(bus_addr_i) >= 0)  rexp = m_mask[req_slot(bus_addr_i)] & m_raw;
      end
      check(bus_rdata_o, rexp, rd_tag);
    end
  endtask

  task automatic model_step();
    bit e;
    logic [63:0] n, w;
    e = !bus_full_i || !is_known(bus_addr_i);
    n = m_ctrl;
    w = bus_wdata_i;
    if (bus_wr_i && !e) begin
      if (mask_slot(bus_addr_i) >= 0) m_mask[mask_slot(bus_addr_i)] = w;
      if (bus_addr_i == 12'h080) begin
        for (int b = 4; b < 12; b++) if (w[b]) n[b] = 1'b0;
        if (w[28]) n[28] = 1'b0;
        if (w[20]) begin
          for (int b = 16; b < 24; b++) n[b] = 1'b0;
        end else begin
          for (int b = 20; b < 24; b++) if (w[b]) n[b] = 1'b1;
          if (m_ctrl[19:16] == 0) n[19:16] = w[19:16];
        end
        for (int i = 0; i < 4; i++) if (w[12+i]) n[8+i] = 1'b1;
        n[43:40] = w[43:40];
      end
    end
    for (int i = 0; i < 4; i++) if (timer_set_i[i]) n[4+i] = 1'b1;
    m_ctrl = n;
    m_raw = dev_irq_i;
    if (legacy_irq_i) m_raw[55] = 1'b1;
  endtask

  task automatic cyc();
    #1;
    compare();
    model_step();
    @(negedge clk_i);
  endtask

  task automatic idle(input int n = 1);
    for (int k = 0; k < n; k++) begin
      bus_rd_i = 0; bus_wr_i = 0; bus_full_i = 1;
      cyc();
    end
  endtask

  task automatic rd(input logic [11:0] a, input string tag, input logic [1:0] cpu = 0,
                    input bit full = 1);
    bus_rd_i = 1; bus_wr_i = 0; bus_addr_i = a; bus_cpu_i = cpu; bus_full_i = full;
    rd_tag = tag;
    cyc();
    bus_rd_i = 0; bus_full_i = 1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d, input bit full = 1);
    bus_rd_i = 0; bus_wr_i = 1; bus_addr_i = a; bus_wdata_i = d; bus_full_i = full;
    cyc();
    bus_wr_i = 0; bus_full_i = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // reset state
    rd(12'h080, "R6 reset ctrl");
    rd(12'h300, "R1 reset raw");
    rd(12'h200, "R2 reset mask");
    for (int c = 0; c < 4; c++) rd(12'h080, "R6 cpu index", 2'(c));

    // raw sampling under several patterns
    dev_irq_i = 64'hdead_beef_0123_4567; idle();
    rd(12'h300, "R1 raw pattern");
    dev_irq_i = 64'h0; legacy_irq_i = 1; idle();
    rd(12'h300, "R1 legacy bit55");
    dev_irq_i = 64'hffff_0000_ffff_0000; legacy_irq_i = 0; idle();
    rd(12'h300, "R1 raw pattern2");

    // masks per CPU, only own CPU updated
    wr(12'h200, 64'h0000_0000_0000_0001);
    wr(12'h240, 64'h0000_0000_0001_0000);
    wr(12'h600, 64'h0080_0000_0000_0000);
    wr(12'h640, 64'hffff_ffff_ffff_ffff);
    rd(12'h200, "R2 mask0"); rd(12'h240, "R2 mask1");
    rd(12'h600, "R2 mask2"); rd(12'h640, "R2 mask3");
    rd(12'h280, "R3 req0"); rd(12'h2c0, "R3 req1");
    rd(12'h680, "R3 req2"); rd(12'h6c0, "R3 req3");
    legacy_irq_i = 1; idle(2);
    rd(12'h680, "R3 req2 legacy");
    // mask write and line change in the same cycle
    dev_irq_i = 64'h1; legacy_irq_i = 0;
    wr(12'h200, 64'h3);
    idle(2);
    dev_irq_i = 64'h0; idle(2);

    // read-only offsets
    dev_irq_i = 64'h00f0; idle();
    wr(12'h300, 64'hffff_ffff_ffff_ffff);
    wr(12'h280, 64'hffff_ffff_ffff_ffff);
    rd(12'h300, "R4 raw unchanged");
    rd(12'h200, "R4 mask0 unchanged");
    rd(12'h280, "R4 req0 view");

    // IPI set/clear
    wr(12'h080, 64'h0000_0000_0000_f000);
    rd(12'h080, "R9 ipi set");
    wr(12'h080, 64'h0000_0000_0000_0500);
    rd(12'h080, "R7 ipi clear");
    wr(12'h080, 64'h0000_0000_0000_1f00);
    rd(12'h080, "R9 set beats clear");
    wr(12'h080, 64'h0000_0000_1000_0000);
    rd(12'h080, "R7 bit28 clear");

    // field with conditional set
    wr(12'h080, 64'h0000_0000_00e0_0000);
    rd(12'h080, "R8 upper set");
    wr(12'h080, 64'h0000_0000_0003_0000);
    rd(12'h080, "R8 lower set when empty");
    wr(12'h080, 64'h0000_0000_000c_0000);
    rd(12'h080, "R8 lower held when nonzero");
    wr(12'h080, 64'h0000_0000_0010_0000);
    rd(12'h080, "R8 clear all");
    wr(12'h080, 64'h0000_0000_0005_0000);
    rd(12'h080, "R8 lower set after clear");

    // timer status
    wr(12'h080, 64'h0000_0000_0000_00f0);
    rd(12'h080, "R10 write cannot set");
    timer_set_i = 4'b0101; idle(); timer_set_i = 0;
    rd(12'h080, "R10 tick set");
    wr(12'h080, 64'h0000_0000_0000_0010);
    rd(12'h080, "R10 sw clear");
    timer_set_i = 4'b0100;
    wr(12'h080, 64'h0000_0000_0000_0040);
    timer_set_i = 0;
    rd(12'h080, "R10 tick beats clear");

    // plain rw field, others ignored
    wr(12'h080, 64'h0004_0a00_0000_0000);
    rd(12'h080, "R11 rw field");
    wr(12'h080, 64'h0000_0000_0000_0000);
    rd(12'h080, "R11 rw cleared");

    // errors
    rd(12'h080, "R12 narrow read", 2'd1, 1'b0);
    wr(12'h080, 64'h0000_0000_0000_f000, 1'b0);
    rd(12'h080, "R12 narrow write ignored");
    rd(12'h008, "R12 unaligned read");
    rd(12'h800, "R12 undefined read");
    wr(12'h800, 64'hffff);
    wr(12'h208, 64'hffff);
    rd(12'h200, "R12 mask0 untouched");

    // reserved offsets
    rd(12'h000, "R13 reserved read");
    wr(12'h380, 64'hffff_ffff);
    rd(12'h380, "R13 reserved stays zero");
    wr(12'hcc0, 64'h1234);
    rd(12'hcc0, "R13 reserved cc0");
    idle(3);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule